// File: doc/BRIEF.md
# Dual Reference Clock Switchover Controller

This block picks which of two reference clocks, REF1 or REF2, feeds a downstream PLL. It reads an 8-bit control word that arrives as a parallel input, an external select pin, and a fault flag for each reference. It returns the chosen clock, a power-enable line for each reference and an indicator that shows which reference is in use. In manual mode the choice comes from a control bit or from the synchronised pin. In automatic mode a persistent REF1 fault moves the selection to REF2. The selection then returns to REF1 once REF1 recovers, unless a hold bit keeps it on REF2.

The clock output passes through a break-before-make multiplexer. That multiplexer removes the old clock on its falling edge and only then admits the new clock on the new clock's falling edge, so no shortened pulse reaches the PLL. A control bit bypasses this path and switches the output directly. Differential mode has a single combined reference: it pins the selection to REF1 and disables automatic failover.

Control word fields (bit: meaning, all zero after reset): 7 bypass deglitch, 6 manual choice of REF2, 5 take manual choice from the pin, 4 automatic failover, 3 hold on REF2 after failover, 2 REF2 power, 1 REF1 power, 0 differential mode.

Top module: `refsel_ctrl`

## Requirements
- R1: After a synchronous active-low reset, ref1_active is 1, both power enables are 0, and the clock output carries REF1.
- R2: In manual mode (bit 4 = 0, bit 5 = 0, bit 0 = 0), bit 6 = 1 selects REF2 and bit 6 = 0 selects REF1. ref1_active reflects the choice one controller clock after the control word changes.
- R3: With bit 5 = 1 in manual mode the choice follows sel_pin (1 = REF2) through a two-flop synchroniser. ref1_active changes on the third controller edge after the pin changes, and bit 6 is ignored.
- R4: Outside effective automatic mode, ref1_pwr_en follows bit 1 and ref2_pwr_en follows bit 2, one cycle after the control word changes.
- R5: With bit 4 = 1 and bit 0 = 0 both power enables are 1, whatever bits 1 and 2 hold.
- R6: In automatic mode a REF1 fault (ref1_fault_n = 0) moves the selection to REF2 on the fifth controller edge after the flag falls. The flag passes through a two-flop synchroniser and must then persist for 2 cycles, so a fault lasting one cycle causes no switch.
- R7: In automatic mode with bit 3 = 0, the selection returns to REF1 on the fifth controller edge after ref1_fault_n returns to 1.
- R8: In automatic mode with bit 3 = 1, the selection stays on REF2 after a failover even when REF1 recovers.
- R9: With bit 0 = 1 the selection is REF1, bits 4, 5 and 6 have no effect on it, and the power enables follow bits 1 and 2.
- R10: With bit 7 = 0 the output follows the selected reference, and no high or low pulse on the output is shorter than the shorter reference half-period, including across switches.
- R11: With bit 7 = 1 the output follows the selected reference from the controller edge that commits the selection.
- R12: In automatic mode a failover to REF2 does not occur while REF2 itself reports a fault (ref2_fault_n = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte | input | 8 | Control word |
| sel_pin | input | 1 | External manual select, 1 = REF2 |
| ref1_clk | input | 1 | Reference clock 1 |
| ref2_clk | input | 1 | Reference clock 2 |
| ref1_fault_n | input | 1 | REF1 fault flag, 0 = REF1 bad |
| ref2_fault_n | input | 1 | REF2 fault flag, 0 = REF2 bad |
| ref_clk_out | output | 1 | Clock to the PLL |
| ref1_pwr_en | output | 1 | REF1 power enable |
| ref2_pwr_en | output | 1 | REF2 power enable |
| ref1_active | output | 1 | 1 = REF1 selected, 0 = REF2 selected |

## Verification
The bench times the pin and fault paths to the exact cycle. A missing or extra synchroniser stage, or a filter of the wrong length, therefore moves the switch a cycle early or late. A single-cycle fault pulse is applied to catch a design that fails over without the persistence filter. A REF1 recovery with the hold bit set catches a design that always reverts. A differential-mode run with automatic mode set catches a design that still fails over or forces power. A monitor of output pulse widths catches a multiplexer that cuts a clock mid-phase, and a count of edges right after a bypassed switch catches a bypass that still waits for the handshake.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
// Shared types for the reference switchover controller.
// Assumes the control word is stable for at least one controller clock.
package refsel_pkg;
    localparam int NREF = 2;

    // Control word, most significant field first (bit 7 .. bit 0).
    typedef struct packed {
        logic no_deglitch;   // 7: direct output switching
        logic reg_ref2;      // 6: manual choice, 1 = REF2
        logic use_pin;       // 5: manual choice comes from pin
        logic auto_en;       // 4: automatic failover
        logic hold_ref2;     // 3: no return to REF1 after failover
        logic ref2_pwr;      // 2: REF2 power
        logic ref1_pwr;      // 1: REF1 power
        logic diff_mode;     // 0: single combined reference
    } refsel_cfg_t;

    localparam int CFG_W = $bits(refsel_cfg_t);
endpackage

// File: rtl/refsel_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for a bus of independent single-bit levels.
// Assumes each bit is a slow level; no multi-bit coherence is provided.
module refsel_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/refsel_persist.sv
`timescale 1ns/1ps
// Persistence filter: the output takes a new input level only after that
// level has differed from the output for STABLE_CYC consecutive cycles.
// Assumes the input is already synchronous to clk.
module refsel_persist #(
    parameter int STABLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Count consecutive disagreeing cycles and commit at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw != filt) begin
            if (cnt == LAST) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/refsel_select.sv
`timescale 1ns/1ps
// Selection policy: manual by bit or pin, automatic failover with optional
// hold, differential override, and the power-enable outputs.
// Assumes fault inputs are synchronised and filtered; behaviour with both
// references bad is to stay on the current reference.
module refsel_select
    import refsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  refsel_cfg_t cfg,
    input  logic        pin_ref2,
    input  logic        ref1_bad,
    input  logic        ref2_bad,
    output logic        sel_ref2,
    output logic        ref1_pwr_en,
    output logic        ref2_pwr_en
);
    logic auto_eff;
    logic sel_next;

    assign auto_eff = cfg.auto_en & ~cfg.diff_mode;

    // Next selection from the active policy.
    always_comb begin
        sel_next = sel_ref2;
        if (cfg.diff_mode) begin
            sel_next = 1'b0;
        end else if (auto_eff) begin
            if (!sel_ref2 && ref1_bad && !ref2_bad) begin
                sel_next = 1'b1;
            end else if (sel_ref2 && !cfg.hold_ref2 && !ref1_bad) begin
                sel_next = 1'b0;
            end
        end else begin
            sel_next = cfg.use_pin ? pin_ref2 : cfg.reg_ref2;
        end
    end

    // Register selection and power enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ref2    <= 1'b0;
            ref1_pwr_en <= 1'b0;
            ref2_pwr_en <= 1'b0;
        end else begin
            sel_ref2    <= sel_next;
            ref1_pwr_en <= auto_eff | cfg.ref1_pwr;
            ref2_pwr_en <= auto_eff | cfg.ref2_pwr;
        end
    end
endmodule

// File: rtl/refsel_clkmux.sv
`timescale 1ns/1ps
// Break-before-make clock multiplexer with a direct-switch bypass.
// Each side syncs its request on its own rising edge, masked by the other
// side's enable, and moves the enable on its falling edge so the output is
// gated only while that clock is low. Assumes both clocks run during reset.
module refsel_clkmux
    import refsel_pkg::*;
(
    input  logic rst_n,
    input  logic ref1_clk,
    input  logic ref2_clk,
    input  logic sel_ref2,
    input  logic bypass,
    output logic clk_out
);
    logic [NREF-1:0] ref_clks;
    logic [NREF-1:0] en_q;
    logic            gated;

    assign ref_clks = {ref2_clk, ref1_clk};

    for (genvar g = 0; g < NREF; g++) begin : g_side
        logic want;
        logic stg;
        logic en;

        assign want    = (g == 0) ? ~sel_ref2 : sel_ref2;
        assign en_q[g] = en;

        // Capture request on rising edge, blocked while the other side is on.
        always_ff @(posedge ref_clks[g]) begin
            if (!rst_n) stg <= 1'b0;
            else        stg <= want & ~en_q[NREF-1-g];
        end

        // Move the enable while this clock is low.
        always_ff @(negedge ref_clks[g]) begin
            if (!rst_n) en <= 1'b0;
            else        en <= stg;
        end
    end

    assign gated   = |(ref_clks & en_q);
    assign clk_out = bypass ? (sel_ref2 ? ref2_clk : ref1_clk) : gated;
endmodule

// File: rtl/refsel_ctrl.sv
`timescale 1ns/1ps
// Dual reference switchover controller top: synchronises the pin and fault
// flags, filters the faults, applies the selection policy and drives the
// output clock multiplexer. Assumes cfg_byte is synchronous to clk.
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int STABLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_byte,
    input  logic             sel_pin,
    input  logic             ref1_clk,
    input  logic             ref2_clk,
    input  logic             ref1_fault_n,
    input  logic             ref2_fault_n,
    output logic             ref_clk_out,
    output logic             ref1_pwr_en,
    output logic             ref2_pwr_en,
    output logic             ref1_active
);
    refsel_cfg_t     cfg;
    logic [2:0]      sync_q;
    logic [NREF-1:0] bad_raw;
    logic [NREF-1:0] bad_filt;
    logic            sel_ref2;

    assign cfg = refsel_cfg_t'(cfg_byte);

    refsel_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_pin, ref2_fault_n, ref1_fault_n}),
        .q     (sync_q)
    );

    assign bad_raw = ~sync_q[NREF-1:0];

    for (genvar r = 0; r < NREF; r++) begin : g_flt
        refsel_persist #(.STABLE_CYC(STABLE_CYC)) u_persist (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (bad_raw[r]),
            .filt  (bad_filt[r])
        );
    end

    refsel_select u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .pin_ref2    (sync_q[2]),
        .ref1_bad    (bad_filt[0]),
        .ref2_bad    (bad_filt[1]),
        .sel_ref2    (sel_ref2),
        .ref1_pwr_en (ref1_pwr_en),
        .ref2_pwr_en (ref2_pwr_en)
    );

    refsel_clkmux u_mux (
        .rst_n    (rst_n),
        .ref1_clk (ref1_clk),
        .ref2_clk (ref2_clk),
        .sel_ref2 (sel_ref2),
        .bypass   (cfg.no_deglitch),
        .clk_out  (ref_clk_out)
    );

    assign ref1_active = ~sel_ref2;
endmodule

// File: rtl/refsel_ctrl_checks.sv
`timescale 1ns/1ps
// Port-level properties of the switchover controller, bound to the top.
module refsel_ctrl_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_byte,
    input logic       ref1_pwr_en,
    input logic       ref2_pwr_en,
    input logic       ref1_active
);
    logic hold_cfg;
    assign hold_cfg = cfg_byte[4] & cfg_byte[3] & ~cfg_byte[0];

    a_r5_auto_power: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_byte[4] && !cfg_byte[0]) |=> (ref1_pwr_en && ref2_pwr_en));

    a_r4_manual_power: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_byte[4] || cfg_byte[0]) |=>
            (ref1_pwr_en == $past(cfg_byte[1]) && ref2_pwr_en == $past(cfg_byte[2])));

    a_r9_diff_ref1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_byte[0] |=> ref1_active);

    a_r2_manual_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_byte[4] && !cfg_byte[5] && !cfg_byte[0]) |=>
            (ref1_active == !$past(cfg_byte[6])));

    a_r8_hold_ref2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cfg && !ref1_active) ##1 hold_cfg |-> !ref1_active);
endmodule

bind refsel_ctrl refsel_ctrl_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_byte    (cfg_byte),
    .ref1_pwr_en (ref1_pwr_en),
    .ref2_pwr_en (ref2_pwr_en),
    .ref1_active (ref1_active)
);

// File: tb/refsel_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for the switchover controller.
module refsel_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = 8'h00;
    logic       pin = 1'b0;
    logic       r1 = 1'b0;
    logic       r2 = 1'b0;
    logic       f1_n = 1'b1;
    logic       f2_n = 1'b1;
    logic       out_clk, p1, p2, act1;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int runts  = 0;
    bit mon_en = 1'b0;
    realtime last_t = 0.0;

    refsel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg), .sel_pin(pin),
        .ref1_clk(r1), .ref2_clk(r2), .ref1_fault_n(f1_n), .ref2_fault_n(f2_n),
        .ref_clk_out(out_clk), .ref1_pwr_en(p1), .ref2_pwr_en(p2),
        .ref1_active(act1)
    );

    always #5  clk = ~clk;   // 100 MHz controller clock
    always #7  r1  = ~r1;    // REF1, 14 ns period
    always #11 r2  = ~r2;    // REF2, 22 ns period

    always @(posedge out_clk) edges++;

    // Pulse-width monitor: shortest reference half-period is 7 ns.
    always @(out_clk) begin
        if (mon_en && last_t > 0.0 && ($realtime - last_t) < 6.9) runts++;
        last_t = $realtime;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int got, input int lo, input int hi);
        checks++;
        if (got < lo || got > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
        end
    endtask

    // Rising output edges over 22 controller cycles (220 ns).
    task automatic count_edges(output int n);
        int start;
        start = edges;
        cyc(22);
        n = edges - start;
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        chk("R1 ref1_active", act1, 1);
        chk("R1 pwr", {p2, p1}, 0);
        cyc(20);
        count_edges(n);
        chk_rng("R1 output is REF1", n, 15, 16);
    endtask

    task automatic t_manual_bit();
        cfg = 8'h40; cyc(1);
        chk("R2 bit6=1 REF2", act1, 0);
        cfg = 8'h00; cyc(1);
        chk("R2 bit6=0 REF1", act1, 1);
    endtask

    task automatic t_pin();
        cfg = 8'h60; pin = 1'b0; cyc(4);
        chk("R3 bit6 ignored in pin mode", act1, 1);
        pin = 1'b1; cyc(2);
        chk("R3 pin not yet through sync", act1, 1);
        cyc(1);
        chk("R3 pin selects REF2 on 3rd edge", act1, 0);
        pin = 1'b0; cyc(3);
        chk("R3 pin back to REF1", act1, 1);
        cfg = 8'h00; cyc(2);
    endtask

    task automatic t_power();
        cfg = 8'h02; cyc(1);
        chk("R4 pwr bits=01", {p2, p1}, 1);
        cfg = 8'h04; cyc(1);
        chk("R4 pwr bits=10", {p2, p1}, 2);
        cfg = 8'h00; cyc(1);
    endtask

    task automatic t_auto();
        cfg = 8'h10; cyc(1);
        chk("R5 auto forces both pwr", {p2, p1}, 3);
        f1_n = 1'b0; cyc(1); f1_n = 1'b1; cyc(10);
        chk("R6 one-cycle fault ignored", act1, 1);
        f1_n = 1'b0; cyc(4);
        chk("R6 fault not yet committed", act1, 1);
        cyc(1);
        chk("R6 failover on 5th edge", act1, 0);
        f1_n = 1'b1; cyc(4);
        chk("R7 still REF2 before commit", act1, 0);
        cyc(1);
        chk("R7 return to REF1", act1, 1);
    endtask

    task automatic t_hold();
        cfg = 8'h18; f1_n = 1'b0; cyc(6);
        chk("R8 failover with hold", act1, 0);
        f1_n = 1'b1; cyc(12);
        chk("R8 stays on REF2", act1, 0);
        cfg = 8'h00; cyc(1);
        chk("R8 manual leaves REF2", act1, 1);
    endtask

    task automatic t_ref2_bad();
        cfg = 8'h10; f2_n = 1'b0; cyc(6);
        f1_n = 1'b0; cyc(10);
        chk("R12 no failover onto bad REF2", act1, 1);
        f1_n = 1'b1; f2_n = 1'b1; cfg = 8'h00; cyc(8);
    endtask

    task automatic t_diff();
        cfg = 8'h71; pin = 1'b1; cyc(1);
        chk("R9 diff ignores bit6/pin", act1, 1);
        chk("R9 diff power not forced", {p2, p1}, 0);
        f1_n = 1'b0; cyc(10);
        chk("R9 diff no failover", act1, 1);
        f1_n = 1'b1; pin = 1'b0; cfg = 8'h00; cyc(8);
    endtask

    task automatic t_mux();
        int n;
        mon_en = 1'b1; last_t = 0.0;
        cfg = 8'h40; cyc(20);
        count_edges(n);
        chk("R10 deglitch output is REF2", n, 10);
        cfg = 8'h00; cyc(20);
        count_edges(n);
        chk_rng("R10 deglitch output is REF1", n, 15, 16);
        for (int i = 0; i < 6; i++) begin
            cfg = (i % 2 == 0) ? 8'h40 : 8'h00;
            cyc(3 + i);
        end
        cfg = 8'h00; cyc(20);
        mon_en = 1'b0;
        chk("R10 no short pulse on output", runts, 0);
    endtask

    task automatic t_bypass();
        int n;
        cfg = 8'h80; cyc(4);
        count_edges(n);
        chk_rng("R11 bypass REF1", n, 15, 16);
        cfg = 8'hC0; cyc(1);
        count_edges(n);
        chk("R11 bypass switches at once", n, 10);
        cfg = 8'h00; cyc(10);
    endtask

    initial begin
        t_reset();
        t_manual_bit();
        t_pin();
        t_power();
        t_auto();
        t_hold();
        t_ref2_bad();
        t_diff();
        t_mux();
        t_bypass();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule